// File: doc/BRIEF.md
# Packet-Atomic Output Merge Stage

This block is the second switching level for a single output of a hierarchical switch. The first level is a set of sub-switches, each serving a small group of input ports. Every sub-switch can route packets to every switch output. At each output, this stage keeps one intermediate FIFO per sub-switch. It merges the FIFO contents onto one output link that carries at most one flit per cycle.

A packet is a run of flits. Its first flit carries a head flag and its last flit carries a tail flag, and a one-flit packet carries both. The stage chooses among FIFOs whose front flit opens a packet, using a rotating priority. It then stays with the chosen FIFO until that packet's tail has left, so packets are never interleaved on the link. Each FIFO gives its upstream path a ready signal that depends only on free space. The output side is a plain valid/ready handshake. The FIFO depth is the main throughput parameter: 64 flits is the preferred value, and 32 or 128 are also supported.

Top module: `grant_merge_mux`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is low and every bit of `src_ready` is high.
- R2: `src_ready[i]` is high exactly when FIFO i holds fewer than DEPTH flits. A flit is stored on a cycle where `src_valid[i]` and `src_ready[i]` are both high.
- R3: Packets leave whole. Once a head flit (`out_head`=1) is offered, every following offered flit comes from the same source until its tail flit (`out_tail`=1) has been accepted. No head flit appears in between.
- R4: At most one flit leaves per cycle. While `out_ready` is high and some FIFO has a packet head at its front, `out_valid` is high with no idle cycle between packets, including packets from different sources.
- R5: While `out_valid` is high and `out_ready` is low, nothing is dequeued. The next cycle offers the same flit, with the same data and flags.
- R6: A new packet is taken from the first source, in rising index order with wrap-around, that has a packet head at its front. The search starts one past the source whose packet finished last, and it starts at source 0 after reset.
- R7: A flit with both head and tail set ends its packet in the cycle it is accepted. Another source's packet can be offered on the very next cycle.
- R8: Flits from one source leave in arrival order with data and flags unchanged.
- R9: If the FIFO of the source holding the link runs empty in the middle of a packet, `out_valid` stays low even when other FIFOs hold packets. Output resumes from that same source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | N_SRC | Per-source flit valid from the sub-switch paths |
| src_data | input | N_SRC*DW | Per-source flit payload; source i occupies bits [i*DW +: DW] |
| src_head | input | N_SRC | Per-source flag: flit opens a packet |
| src_tail | input | N_SRC | Per-source flag: flit closes a packet |
| src_ready | output | N_SRC | Per-source backpressure: FIFO has a free entry |
| out_valid | output | 1 | Output flit valid |
| out_data | output | DW | Output flit payload |
| out_head | output | 1 | Output flit opens a packet |
| out_tail | output | 1 | Output flit closes a packet |
| out_ready | input | 1 | Output link accepts a flit this cycle |

## Verification
The bench builds the block with four sources, eight-entry FIFOs and 16-bit flits. With that depth, a source can be filled to the point where ready drops within a few cycles. A depth of eight also still holds the longest six-flit packet. With four sources, every rotation of the round-robin pointer, every packet length from one to six, and the mid-packet starvation case are covered many times across output stall and sparse input patterns.

// File: rtl/merge_pkg.sv
package merge_pkg;

    // Packet delimiting flags carried alongside every flit.
    typedef struct packed {
        logic head;
        logic tail;
    } flit_mark_t;

    // Whether the output link is free for a new packet or held by one source.
    typedef enum logic {
        SEL_OPEN = 1'b0,
        SEL_HELD = 1'b1
    } sel_mode_e;

    // Next source index in circular order.
    function automatic int next_src(input int cur, input int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/mrg_fifo.sv
module mrg_fifo
    import merge_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  flit_mark_t    push_mark,
    output logic          push_ready,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output flit_mark_t    head_mark,
    output logic          not_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        flit_mark_t    mark;
        logic [DW-1:0] data;
    } slot_t;

    slot_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    logic [CW-1:0]  fill;
    logic           do_push;
    logic           do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign push_ready = (fill != CW'(DEPTH));
    assign not_empty  = (fill != '0);
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && not_empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= '{mark: push_mark, data: push_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign head_data = mem[rd_ptr].data;
    assign head_mark = mem[rd_ptr].mark;

endmodule

// File: rtl/mrg_rr_pick.sv
module mrg_rr_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Walk from the far end back to the base so the last hit is the nearest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = int'(base) + k;
            if (j >= N) j = j - N;
            if (req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end

endmodule

// File: rtl/mrg_sel_ctrl.sv
module mrg_sel_ctrl
    import merge_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  ne_v,
    input  logic [N-1:0]  hd_v,
    input  logic [N-1:0]  tl_v,
    input  logic          out_ready,
    output logic          grant_valid,
    output logic [IW-1:0] cur_idx,
    output logic [N-1:0]  pop_v
);
    sel_mode_e     mode_q;
    logic [IW-1:0] sel_q;
    logic [IW-1:0] ptr_q;
    logic [N-1:0]  eligible;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          fire;

    assign eligible = ne_v & hd_v;

    mrg_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req   (eligible),
        .base  (ptr_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        if (mode_q == SEL_HELD) begin
            cur_idx     = sel_q;
            grant_valid = ne_v[sel_q];
        end else begin
            cur_idx     = pick_idx;
            grant_valid = pick_found;
        end
    end

    assign fire = grant_valid && out_ready;

    always_comb begin
        pop_v = '0;
        if (fire) pop_v[cur_idx] = 1'b1;
    end

    // Any offered flit that does not finish its packet holds the link.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SEL_OPEN;
            sel_q  <= '0;
            ptr_q  <= '0;
        end else if (grant_valid) begin
            if (fire && tl_v[cur_idx]) begin
                mode_q <= SEL_OPEN;
                ptr_q  <= IW'(next_src(int'(cur_idx), N));
            end else begin
                mode_q <= SEL_HELD;
                sel_q  <= cur_idx;
            end
        end
    end

endmodule

// File: rtl/grant_merge_mux.sv
module grant_merge_mux
    import merge_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int DEPTH = 64,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    src_valid,
    input  logic [N_SRC*DW-1:0] src_data,
    input  logic [N_SRC-1:0]    src_head,
    input  logic [N_SRC-1:0]    src_tail,
    output logic [N_SRC-1:0]    src_ready,
    output logic                out_valid,
    output logic [DW-1:0]       out_data,
    output logic                out_head,
    output logic                out_tail,
    input  logic                out_ready
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] ne_v;
    logic [N_SRC-1:0] hd_v;
    logic [N_SRC-1:0] tl_v;
    logic [N_SRC-1:0] pop_v;
    logic [DW-1:0]    q_data [N_SRC];
    logic [IW-1:0]    cur_idx;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        flit_mark_t in_mark;
        flit_mark_t q_mark;

        assign in_mark = '{head: src_head[g], tail: src_tail[g]};

        mrg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push_valid (src_valid[g]),
            .push_data  (src_data[g*DW +: DW]),
            .push_mark  (in_mark),
            .push_ready (src_ready[g]),
            .pop        (pop_v[g]),
            .head_data  (q_data[g]),
            .head_mark  (q_mark),
            .not_empty  (ne_v[g])
        );

        assign hd_v[g] = q_mark.head;
        assign tl_v[g] = q_mark.tail;
    end

    mrg_sel_ctrl #(.N(N_SRC), .IW(IW)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .ne_v        (ne_v),
        .hd_v        (hd_v),
        .tl_v        (tl_v),
        .out_ready   (out_ready),
        .grant_valid (out_valid),
        .cur_idx     (cur_idx),
        .pop_v       (pop_v)
    );

    assign out_data = q_data[cur_idx];
    assign out_head = hd_v[cur_idx];
    assign out_tail = tl_v[cur_idx];

endmodule

// File: rtl/mrg_chk.sv
module mrg_chk #(
    parameter int N_SRC = 8,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_valid,
    input logic [N_SRC-1:0] src_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DW-1:0]    out_data,
    input logic             out_head,
    input logic             out_tail,
    input logic [N_SRC-1:0] pop_v
);
    logic in_pkt;

    always_ff @(posedge clk) begin
        if (rst)                         in_pkt <= 1'b0;
        else if (out_valid && out_ready) in_pkt <= !out_tail;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid) else $error("reset idle");            // R1

    for (genvar g = 0; g < N_SRC; g++) begin : g_rdy
        AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
            $fell(src_ready[g]) |-> $past(src_valid[g])) else $error("ready drop"); // R2
    end

    AST_HEAD_OPENS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !in_pkt) |-> out_head) else $error("head opens");  // R3

    AST_NO_MIDHEAD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_pkt) |-> !out_head) else $error("mid head");    // R3

    AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
        $countones(pop_v) <= 1) else $error("one pop");                  // R4

    AST_POP_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
        (|pop_v) |-> (out_valid && out_ready)) else $error("pop fire");  // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_head) && $stable(out_tail)))
        else $error("stall hold");                                       // R5

endmodule

bind grant_merge_mux mrg_chk #(.N_SRC(N_SRC), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_head  (out_head),
    .out_tail  (out_tail),
    .pop_v     (pop_v)
);

// File: tb/test_grant_merge_mux.sv
module test_grant_merge_mux;
    localparam int N     = 4;
    localparam int DEPTH = 8;
    localparam int DW    = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    src_valid = '0;
    logic [N*DW-1:0] src_data = '0;
    logic [N-1:0]    src_head = '0;
    logic [N-1:0]    src_tail = '0;
    logic [N-1:0]    src_ready;
    logic            out_valid;
    logic [DW-1:0]   out_data;
    logic            out_head;
    logic            out_tail;
    logic            out_ready = 1'b0;

    always #4 clk = ~clk;

    grant_merge_mux #(.N_SRC(N), .DEPTH(DEPTH), .DW(DW)) i_grant_merge_mux (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_data(src_data),
        .src_head(src_head), .src_tail(src_tail), .src_ready(src_ready),
        .out_valid(out_valid), .out_data(out_data),
        .out_head(out_head), .out_tail(out_tail), .out_ready(out_ready)
    );

    int tests = 0;
    int fails = 0;
    int total_cyc = 0;
    bit timed_out = 0;

    // Entry layout: [17] head, [16] tail, [15:12] source, [11:0] sequence.
    logic [17:0] gen_q   [N][$];
    logic [17:0] model_q [N][$];
    int          seq     [N];
    bit          hold_on = 0;
    int          hold_src = 0;
    int          rr_ptr = 0;
    bit          prev_stall = 0;
    logic [17:0] prev_out = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic load(input int s, input int npk, input int base, input int fixed_len);
        for (int k = 0; k < npk; k++) begin
            int len;
            len = (fixed_len > 0) ? fixed_len : 1 + ((base + k) % 6);
            for (int f = 0; f < len; f++) begin
                gen_q[s].push_back({(f == 0), (f == len - 1), 4'(s), 12'(seq[s])});
                seq[s]++;
            end
        end
    endtask

    function automatic bit all_empty();
        for (int s = 0; s < N; s++)
            if (gen_q[s].size() != 0 || model_q[s].size() != 0) return 0;
        return 1;
    endfunction

    task automatic run(input int max_cyc, input int rdy_mode, input int vmode,
                       input logic [N-1:0] mask, input bit stop_empty);
        for (int c = 0; c < max_cyc; c++) begin
            logic [17:0] obs;
            bit          exp_v;
            int          exp_src;
            int          src;
            if (stop_empty && all_empty()) break;
            if (total_cyc > 150000) begin
                timed_out = 1;
                break;
            end
            @(negedge clk);
            total_cyc++;
            case (rdy_mode)
                0:       out_ready = 1'b0;
                1:       out_ready = 1'b1;
                2:       out_ready = (c % 3) != 0;
                default: out_ready = (c % 5) >= 2;
            endcase
            for (int s = 0; s < N; s++) begin
                bit en;
                case (vmode)
                    0:       en = 1;
                    1:       en = ((c + s) % 4) != 0;
                    default: en = (((c / 7) + s) % 3) == 0;
                endcase
                en = en && mask[s] && (gen_q[s].size() != 0);
                src_valid[s] = en;
                if (gen_q[s].size() != 0) begin
                    src_head[s]            = gen_q[s][0][17];
                    src_tail[s]            = gen_q[s][0][16];
                    src_data[s*DW +: DW]   = gen_q[s][0][15:0];
                end
            end
            #1;
            // R2: ready reflects free space in each FIFO
            for (int s = 0; s < N; s++)
                check(src_ready[s] == (model_q[s].size() < DEPTH), "R2", "src_ready",
                      int'(src_ready[s]), int'(model_q[s].size() < DEPTH));
            obs = {out_head, out_tail, out_data};
            if (hold_on) begin
                exp_v = model_q[hold_src].size() != 0;
                check(out_valid == exp_v, "R9", "out_valid while held", int'(out_valid), int'(exp_v));
            end else begin
                exp_v = 0;
                for (int s = 0; s < N; s++)
                    if (model_q[s].size() != 0 && model_q[s][0][17]) exp_v = 1;
                check(out_valid == exp_v, "R4 R7", "out_valid while open", int'(out_valid), int'(exp_v));
            end
            if (prev_stall)
                check(out_valid && obs == prev_out, "R5", "stalled flit held", int'(obs), int'(prev_out));
            if (out_valid) begin
                src = int'(out_data[15:12]);
                if (src >= N) begin
                    check(0, "R8", "source field", src, 0);
                end else begin
                    if (hold_on) begin
                        check(src == hold_src, "R3", "packet source", src, hold_src);
                    end else begin
                        exp_src = -1;
                        for (int k = 0; k < N; k++) begin
                            int j;
                            j = (rr_ptr + k) % N;
                            if (exp_src < 0 && model_q[j].size() != 0 && model_q[j][0][17]) exp_src = j;
                        end
                        check(src == exp_src, "R6", "round-robin source", src, exp_src);
                        check(out_head == 1'b1, "R3", "packet opens with head", int'(out_head), 1);
                    end
                    if (model_q[src].size() == 0) begin
                        check(0, "R8", "flit from empty source", int'(obs), 0);
                    end else begin
                        check(obs == model_q[src][0], "R8", "flit content", int'(obs), int'(model_q[src][0]));
                        if (out_ready) begin
                            void'(model_q[src].pop_front());
                            if (out_tail) begin
                                hold_on = 0;
                                rr_ptr  = (src + 1) % N;
                            end else begin
                                hold_on  = 1;
                                hold_src = src;
                            end
                        end else begin
                            hold_on  = 1;
                            hold_src = src;
                        end
                    end
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = obs;
            for (int s = 0; s < N; s++)
                if (src_valid[s] && src_ready[s])
                    model_q[s].push_back(gen_q[s].pop_front());
        end
    endtask

    initial begin
        for (int s = 0; s < N; s++) seq[s] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(src_ready == '1, "R1", "src_ready after reset", int'(src_ready), (1 << N) - 1);

        // Fill one FIFO with the output blocked: ready must drop at DEPTH (R2, R5).
        load(0, 3, 3, 0);
        run(20, 0, 0, 4'b0001, 0);
        // Drain everything with a full-rate output (R4, R6, R8).
        for (int s = 0; s < N; s++) load(s, 6, s, 0);
        run(3000, 1, 0, 4'b1111, 1);
        // One-flit packets from all sources back to back (R7).
        for (int s = 0; s < N; s++) load(s, 5, 0, 1);
        run(3000, 1, 0, 4'b1111, 1);
        // Output stalls with sparse inputs (R3, R5).
        for (int s = 0; s < N; s++) load(s, 8, 2 * s + 1, 0);
        run(6000, 2, 1, 4'b1111, 1);
        // Bursty inputs starve a held source mid-packet (R9).
        for (int s = 0; s < N; s++) load(s, 8, 3 * s, 0);
        run(8000, 3, 2, 4'b1111, 1);

        if (timed_out || !all_empty()) begin
            tests++;
            fails++;
            $display("FAIL R4 watchdog: got %0d expected %0d", total_cyc, 150000);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule